// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block keeps the receive-side state of a set of USB device endpoints and decides the handshake returned for every OUT or SETUP transaction. A token decoder delivers the addressed endpoint and whether the token was a SETUP. If that endpoint is not armed, the block refuses at once: it answers NAK or STALL, or stays silent, and keeps the packet-memory write enable low. If the endpoint is armed, the block opens the write window for the buffer writer. It then waits for the end-of-packet result, which carries the CRC verdict, any line error and the overrun flag.

A clean packet is acknowledged. The endpoint then disarms itself to NAK, its data toggle flips, and its transfer-complete flag is raised so that software can collect the data. Errors produce silence and a sticky error flag. An overrun produces STALL. Neither kind of failure touches the endpoint state. A small register port lets software read an endpoint's state one cycle after selecting it. Through the same port software can clear the transfer-complete flag, re-arm the endpoint by writing Valid, and clear the error flag.

Top module: `usb_out_hs_ctrl`

## Requirements
- R1: A token that meets an endpoint whose status is NAK (2'b10) yields a NAK handshake. Status STALL (2'b01) yields a STALL handshake. Disabled (2'b00) yields no handshake. In all three cases mem_wr_en stays low.
- R2: A token that meets status Valid (2'b11) raises mem_wr_en from the cycle after the token until the transaction ends. Tokens that arrive while a transaction is open are ignored.
- R3: The handshake is a one-cycle hs_valid pulse, with hs_code 2'b00 = ACK, 2'b01 = NAK and 2'b10 = STALL. For a refused token the pulse comes in the cycle after the token; for an open transaction it comes in the cycle after pkt_end. ACK is given only when pkt_end comes with pkt_crc_ok=1, pkt_err=0 and pkt_ovr=0.
- R4: pkt_end with pkt_crc_ok=0 or pkt_err=1 gives no handshake and sets err_flag in the following cycle. The next token is served normally with no software action.
- R5: pkt_end with a good CRC, no error and pkt_ovr=1 gives a STALL handshake and does not raise the transfer-complete flag.
- R6: After an ACK, the endpoint's data toggle is inverted, its status becomes NAK, its transfer-complete flag is 1 and its SETUP bit records the token type. The read word is laid out as [1:0] status, [2] toggle, [3] transfer-complete, [4] SETUP.
- R7: A failed transaction leaves the toggle, status, transfer-complete and SETUP bits of every endpoint unchanged.
- R8: A software write with sw_ctr_wval=0 clears the selected endpoint's transfer-complete flag, and sw_ctr_wval=1 leaves it as it is. When hardware sets the flag in the same cycle as a clear, the flag ends at 1.
- R9: If no pkt_end arrives within TIMEOUT cycles after an accepted token, the transaction is closed with no handshake and err_flag set, and the endpoint state is unchanged.
- R10: A software write with sw_stat_wr=1 loads sw_stat_val into the selected endpoint's status. sw_err_clr clears err_flag, and a hardware error in the same cycle wins. After reset every endpoint reads 5'b00000 and err_flag is 0.
- R11: sw_rd_data shows the state of endpoint sw_rd_ep as it was before the clock edge that captured the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | OUT/SETUP token pulse |
| tok_ep | input | EP_W | Addressed endpoint |
| tok_setup | input | 1 | Token was SETUP |
| pkt_end | input | 1 | End of data packet pulse |
| pkt_crc_ok | input | 1 | CRC verdict of the packet |
| pkt_err | input | 1 | Bit-stuff or framing error seen |
| pkt_ovr | input | 1 | Buffer writer ran out of space |
| mem_wr_en | output | 1 | Packet memory writes allowed |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | Handshake kind |
| err_flag | output | 1 | Sticky reception error flag |
| sw_wr | input | 1 | Software write strobe |
| sw_ep | input | EP_W | Endpoint for the write |
| sw_ctr_wval | input | 1 | Value written to transfer-complete |
| sw_stat_wr | input | 1 | Also load the status field |
| sw_stat_val | input | 2 | New status value |
| sw_err_clr | input | 1 | Clear the error flag |
| sw_rd_ep | input | EP_W | Endpoint to read |
| sw_rd_data | output | 5 | Registered endpoint state |

## Verification
The bench aims at the cycle where a software clear of the transfer-complete flag meets the hardware set. A design that let software win there would lose a completion notice. It also drives a pkt_end on exactly the last cycle of the turnaround window, and tokens that arrive in the middle of an open transaction. A timer that is off by one would drop valid packets, and a design that re-arbitrates mid-transaction would corrupt another endpoint. Failures with overrun and with errors are mixed with clean packets on the same endpoint. A design that flips the toggle or disarms the endpoint on failure, or that treats an overrun as an error, diverges from the cycle-by-cycle model.

// File: rtl/uoh_pkg.sv
package uoh_pkg;
  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } ep_stat_t;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_kind_t;

  typedef struct packed {
    logic     setup;
    logic     ctr;
    logic     dtog;
    ep_stat_t stat;
  } ep_rec_t;
endpackage

// File: rtl/uoh_ep_bank.sv
module uoh_ep_bank
  import uoh_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [EP_W-1:0] commit_ep,
  input  logic            commit_setup,
  input  logic            sw_wr,
  input  logic [EP_W-1:0] sw_ep,
  input  logic            sw_ctr_wval,
  input  logic            sw_stat_wr,
  input  logic [1:0]      sw_stat_val,
  input  logic [EP_W-1:0] lk_ep,
  input  logic [EP_W-1:0] rd_ep,
  output ep_stat_t        lk_stat,
  output ep_rec_t         rd_rec,
  output logic [NUM_EP-1:0] ctr_vec
);
  ep_rec_t recs [NUM_EP];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_rec_t rec;
    logic    sw_hit, hw_hit;
    assign sw_hit = sw_wr && (sw_ep == EP_W'(i));
    assign hw_hit = commit && (commit_ep == EP_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        rec <= '0;
      end else begin
        if (sw_hit) begin
          if (!sw_ctr_wval) rec.ctr  <= 1'b0;
          if (sw_stat_wr)   rec.stat <= ep_stat_t'(sw_stat_val);
        end
        // hardware completion overrides a same-cycle software write
        if (hw_hit) begin
          rec.ctr   <= 1'b1;
          rec.stat  <= ST_NAK;
          rec.dtog  <= ~rec.dtog;
          rec.setup <= commit_setup;
        end
      end
    end
    assign recs[i]    = rec;
    assign ctr_vec[i] = rec.ctr;
  end

  assign lk_stat = recs[lk_ep].stat;

  always_ff @(posedge clk) begin
    if (rst) rd_rec <= '0;
    else     rd_rec <= recs[rd_ep];
  end
endmodule

// File: rtl/uoh_txn_fsm.sv
module uoh_txn_fsm
  import uoh_pkg::*;
#(
  parameter int EP_W    = 2,
  parameter int TIMEOUT = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tok_valid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            tok_setup,
  input  ep_stat_t        tok_stat,
  input  logic            pkt_end,
  input  logic            pkt_crc_ok,
  input  logic            pkt_err,
  input  logic            pkt_ovr,
  input  logic            sw_err_clr,
  output logic            busy,
  output logic [EP_W-1:0] act_ep,
  output logic            commit,
  output logic            commit_setup,
  output logic            hs_valid,
  output hs_kind_t        hs_code,
  output logic            err_flag
);
  localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  typedef enum logic {S_IDLE, S_RX} st_t;
  st_t              state;
  logic [TMR_W-1:0] timer;
  logic             act_setup;
  logic             fin_good, fin_bad, fin_tmo;

  assign busy = (state == S_RX);

  always_comb begin
    fin_good = busy && pkt_end && pkt_crc_ok && !pkt_err && !pkt_ovr;
    fin_bad  = busy && pkt_end && (!pkt_crc_ok || pkt_err);
    fin_tmo  = busy && !pkt_end && (timer == TMR_LAST);
  end

  assign commit       = fin_good;
  assign commit_setup = act_setup;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      timer     <= '0;
      act_ep    <= '0;
      act_setup <= 1'b0;
      hs_valid  <= 1'b0;
      hs_code   <= HS_ACK;
      err_flag  <= 1'b0;
    end else begin
      hs_valid <= 1'b0;
      if (sw_err_clr)         err_flag <= 1'b0;
      if (fin_bad || fin_tmo) err_flag <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (tok_valid) begin
            unique case (tok_stat)
              ST_VALID: begin
                state     <= S_RX;
                timer     <= '0;
                act_ep    <= tok_ep;
                act_setup <= tok_setup;
              end
              ST_NAK: begin
                hs_valid <= 1'b1;
                hs_code  <= HS_NAK;
              end
              ST_STALL: begin
                hs_valid <= 1'b1;
                hs_code  <= HS_STALL;
              end
              default: ;
            endcase
          end
        end
        S_RX: begin
          if (pkt_end) begin
            state <= S_IDLE;
            if (fin_good) begin
              hs_valid <= 1'b1;
              hs_code  <= HS_ACK;
            end else if (!fin_bad) begin
              hs_valid <= 1'b1;
              hs_code  <= HS_STALL;
            end
          end else if (fin_tmo) begin
            state <= S_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_out_hs_ctrl.sv
module usb_out_hs_ctrl
  import uoh_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int TIMEOUT = 16,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tok_valid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            tok_setup,
  input  logic            pkt_end,
  input  logic            pkt_crc_ok,
  input  logic            pkt_err,
  input  logic            pkt_ovr,
  output logic            mem_wr_en,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic            err_flag,
  input  logic            sw_wr,
  input  logic [EP_W-1:0] sw_ep,
  input  logic            sw_ctr_wval,
  input  logic            sw_stat_wr,
  input  logic [1:0]      sw_stat_val,
  input  logic            sw_err_clr,
  input  logic [EP_W-1:0] sw_rd_ep,
  output logic [4:0]      sw_rd_data
);
  ep_stat_t          lk_stat;
  ep_rec_t           rd_rec;
  logic [NUM_EP-1:0] ctr_vec;
  logic [EP_W-1:0]   act_ep;
  logic              busy, commit, commit_setup;
  hs_kind_t          hs_kind;

  uoh_ep_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_bank (
    .clk(clk), .rst(rst),
    .commit(commit), .commit_ep(act_ep), .commit_setup(commit_setup),
    .sw_wr(sw_wr), .sw_ep(sw_ep), .sw_ctr_wval(sw_ctr_wval),
    .sw_stat_wr(sw_stat_wr), .sw_stat_val(sw_stat_val),
    .lk_ep(tok_ep), .rd_ep(sw_rd_ep),
    .lk_stat(lk_stat), .rd_rec(rd_rec), .ctr_vec(ctr_vec)
  );

  uoh_txn_fsm #(.EP_W(EP_W), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_setup(tok_setup),
    .tok_stat(lk_stat),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .pkt_err(pkt_err),
    .pkt_ovr(pkt_ovr), .sw_err_clr(sw_err_clr),
    .busy(busy), .act_ep(act_ep), .commit(commit),
    .commit_setup(commit_setup),
    .hs_valid(hs_valid), .hs_code(hs_kind), .err_flag(err_flag)
  );

  assign mem_wr_en  = busy;
  assign hs_code    = hs_kind;
  assign sw_rd_data = rd_rec;
endmodule

// File: rtl/uoh_checker.sv
module uoh_checker #(
  parameter int NUM_EP = 4,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_valid,
  input logic [1:0]        tok_stat,
  input logic              mem_wr_en,
  input logic              pkt_end,
  input logic              pkt_crc_ok,
  input logic              pkt_err,
  input logic              pkt_ovr,
  input logic              hs_valid,
  input logic [1:0]        hs_code,
  input logic              err_flag,
  input logic [NUM_EP-1:0] ctr_vec,
  input logic [EP_W-1:0]   act_ep
);
  // R1: a refused token never opens the write window
  a_r1_refuse_no_write: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !mem_wr_en && tok_stat != 2'b11) |=> !mem_wr_en);

  // R3: ACK only follows a clean end of packet
  a_r3_ack_clean: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == 2'b00) |->
      $past(mem_wr_en && pkt_end && pkt_crc_ok && !pkt_err && !pkt_ovr));

  // R4: errors are silent and flagged
  a_r4_err_silent: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && pkt_end && (!pkt_crc_ok || pkt_err)) |=> (!hs_valid && err_flag));

  // R5: overrun answers STALL
  a_r5_ovr_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && pkt_end && pkt_crc_ok && !pkt_err && pkt_ovr) |=>
      (hs_valid && hs_code == 2'b10));

  // R6: an ACK coincides with the transfer-complete flag of that endpoint
  a_r6_ctr_on_ack: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == 2'b00) |-> ctr_vec[act_ep]);
endmodule

bind usb_out_hs_ctrl uoh_checker #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_stat(lk_stat),
  .mem_wr_en(mem_wr_en), .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
  .pkt_err(pkt_err), .pkt_ovr(pkt_ovr), .hs_valid(hs_valid),
  .hs_code(hs_code), .err_flag(err_flag), .ctr_vec(ctr_vec), .act_ep(act_ep)
);

// File: tb/sim_usb_out_hs_ctrl.sv
`timescale 1ns/1ps
module sim_usb_out_hs_ctrl;
  localparam int NEP = 4;
  localparam int TMO = 16;

  logic clk = 0, rst = 1;
  logic tok_valid = 0, tok_setup = 0, pkt_end = 0, pkt_crc_ok = 0, pkt_err = 0, pkt_ovr = 0;
  logic [1:0] tok_ep = 0, sw_ep = 0, sw_rd_ep = 0, sw_stat_val = 0;
  logic sw_wr = 0, sw_ctr_wval = 1, sw_stat_wr = 0, sw_err_clr = 0;
  logic mem_wr_en, hs_valid, err_flag;
  logic [1:0] hs_code;
  logic [4:0] sw_rd_data;

  always #5 clk = ~clk;

  usb_out_hs_ctrl #(.NUM_EP(NEP), .TIMEOUT(TMO)) u0 (.*);

  int vecs = 0, bad = 0;

  // behavioural reference model
  int  m_stat [NEP];
  bit  m_tog [NEP], m_ctr [NEP], m_set [NEP];
  bit  m_busy, m_err, m_hsv, m_tsetup;
  int  m_hsc, m_cnt, m_ep, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_stat[i]) begin m_stat[i] = 0; m_tog[i] = 0; m_ctr[i] = 0; m_set[i] = 0; end
      m_busy = 0; m_err = 0; m_hsv = 0; m_hsc = 0; m_cnt = 0; m_ep = 0; m_rd = 0; m_tsetup = 0;
    end else begin
      m_rd = m_set[sw_rd_ep]*16 + m_ctr[sw_rd_ep]*8 + m_tog[sw_rd_ep]*4 + m_stat[sw_rd_ep];
      m_hsv = 0;
      if (sw_wr) begin
        if (!sw_ctr_wval) m_ctr[sw_ep] = 0;
        if (sw_stat_wr) m_stat[sw_ep] = sw_stat_val;
      end
      if (sw_err_clr) m_err = 0;
      if (m_busy) begin
        if (pkt_end) begin
          m_busy = 0;
          if (!pkt_crc_ok || pkt_err) m_err = 1;
          else if (pkt_ovr) begin m_hsv = 1; m_hsc = 2; end
          else begin
            m_hsv = 1; m_hsc = 0;
            m_tog[m_ep] = !m_tog[m_ep]; m_stat[m_ep] = 2; m_ctr[m_ep] = 1; m_set[m_ep] = m_tsetup;
          end
        end else if (m_cnt == TMO - 1) begin
          m_busy = 0; m_err = 1;
        end else m_cnt++;
      end else if (tok_valid) begin
        if (m_stat[tok_ep] == 3) begin m_busy = 1; m_cnt = 0; m_ep = tok_ep; m_tsetup = tok_setup; end
        else if (m_stat[tok_ep] == 2) begin m_hsv = 1; m_hsc = 1; end
        else if (m_stat[tok_ep] == 1) begin m_hsv = 1; m_hsc = 2; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (!rst) begin
    chk(hs_valid == m_hsv, "R3 hs_valid", hs_valid, m_hsv);
    if (m_hsv) chk(hs_code == 2'(m_hsc), "R3 hs_code", hs_code, m_hsc);
    chk(mem_wr_en == m_busy, "R2 mem_wr_en", mem_wr_en, m_busy);
    chk(err_flag == m_err, "R4 err_flag", err_flag, m_err);
    chk(sw_rd_data == 5'(m_rd), "R11 sw_rd_data", sw_rd_data, m_rd);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic swr(input int ep, input bit cval, input bit swr_stat, input int st);
    sw_wr = 1; sw_ep = 2'(ep); sw_ctr_wval = cval; sw_stat_wr = swr_stat; sw_stat_val = 2'(st);
    cyc(1);
    sw_wr = 0; sw_ctr_wval = 1; sw_stat_wr = 0;
  endtask

  task automatic tok(input int ep, input bit setup);
    tok_valid = 1; tok_ep = 2'(ep); tok_setup = setup;
    cyc(1);
    tok_valid = 0;
  endtask

  task automatic pend(input bit crc, input bit er, input bit ov);
    pkt_end = 1; pkt_crc_ok = crc; pkt_err = er; pkt_ovr = ov;
    cyc(1);
    pkt_end = 0; pkt_crc_ok = 0; pkt_err = 0; pkt_ovr = 0;
  endtask

  task automatic rd_expect(input int ep, input int exp, input string req);
    sw_rd_ep = 2'(ep);
    cyc(1);
    chk(sw_rd_data == 5'(exp), req, sw_rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    // R10: reset state
    for (int e = 0; e < NEP; e++) rd_expect(e, 0, "R10 reset");
    chk(err_flag == 0, "R10 err reset", err_flag, 0);
    // arm: ep0,ep1 Valid, ep2 NAK, ep3 STALL (R10 status write)
    swr(0, 1, 1, 3); swr(1, 1, 1, 3); swr(2, 1, 1, 2); swr(3, 1, 1, 1);
    rd_expect(3, 5'b00001, "R10 stat write");
    // R2: clean OUT to ep0, with a stray token mid-packet (ignored)
    tok(0, 0); cyc(2); tok(3, 0); cyc(2);
    pend(1, 0, 0);
    cyc(1);
    rd_expect(0, 5'b01110, "R6 after ack"); // ctr=1, tog=1, NAK
    // R1: ep0 now NAK, ep3 STALL, ep2 disabled -> silent
    tok(0, 0); cyc(2); tok(3, 0); cyc(2);
    swr(2, 1, 1, 0); tok(2, 0); cyc(2);
    // R4 / R7: SETUP to ep1 with CRC fault, then stuff error
    tok(1, 1); cyc(3); pend(0, 0, 0); cyc(2);
    rd_expect(1, 5'b00011, "R7 after crc fail");
    tok(1, 1); cyc(1); pend(1, 1, 0); cyc(2);
    swr(0, 1, 0, 0); sw_err_clr = 1; cyc(1); sw_err_clr = 0;
    // R5: overrun -> STALL, no ctr
    tok(1, 0); cyc(2); pend(1, 0, 1); cyc(1);
    rd_expect(1, 5'b00011, "R5 R7 after overrun");
    // R6: SETUP clean on ep1 records setup
    tok(1, 1); cyc(4); pend(1, 0, 0); cyc(1);
    rd_expect(1, 5'b11110, "R6 setup recorded");
    // R8: write 1 no effect, write 0 clears
    swr(1, 1, 0, 0); rd_expect(1, 5'b11110, "R8 write one");
    swr(1, 0, 0, 0); rd_expect(1, 5'b10110, "R8 write zero");
    // R8: clear in the same cycle as hardware set -> set wins
    swr(0, 1, 1, 3);
    tok(0, 0); cyc(2);
    pkt_end = 1; pkt_crc_ok = 1; sw_wr = 1; sw_ep = 0; sw_ctr_wval = 0;
    cyc(1);
    pkt_end = 0; pkt_crc_ok = 0; sw_wr = 0; sw_ctr_wval = 1;
    rd_expect(0, 5'b01000 | 5'b00010, "R8 hw set wins");
    // R9: timeout, then pkt_end exactly on the last window cycle
    swr(1, 0, 1, 3);
    tok(1, 0); cyc(TMO + 2);
    rd_expect(1, 5'b10111, "R9 state after timeout");
    chk(err_flag == 1, "R9 err_flag", err_flag, 1);
    tok(1, 0); cyc(TMO - 1); pend(1, 0, 0); cyc(1);
    // R10: err clear with simultaneous hw error -> stays set
    swr(1, 1, 1, 3); tok(1, 0); cyc(1);
    pkt_end = 1; pkt_crc_ok = 0; sw_err_clr = 1; cyc(1);
    pkt_end = 0; sw_err_clr = 0;
    chk(err_flag == 1, "R10 hw err wins", err_flag, 1);
    // random mix
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      sw_rd_ep = 2'($urandom_range(0, 3));
      if (r < 3) swr($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 3));
      else if (r == 3) begin sw_err_clr = 1; cyc(1); sw_err_clr = 0; end
      else begin
        tok($urandom_range(0, 3), 1'($urandom_range(0, 1)));
        cyc($urandom_range(0, TMO + 2));
        pend(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 5) == 0),
             1'($urandom_range(0, 4) == 0));
        cyc($urandom_range(0, 2));
      end
    end
    cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule